// File: doc/BRIEF.md
# Quad-SPI Flash Transfer Sequencer

This block is a SPI master that runs one complete serial-flash transaction per start request. A transaction always opens with a one-byte opcode. An address of zero to four bytes may follow, then a run of dummy clocks, then bytes written to the flash, and finally bytes read back. A three-bit format code chooses how many data lines (one, two or four) the opcode phase, the address phase and the data phases each use. The block drives one active-low select line, a serial clock that idles low, and four data lines, each with its own output enable.

A client places the opcode, address, address byte count, dummy clock count and both byte counts on the start inputs, then pulses `start_i` while the block is idle. Write bytes are pulled from a byte stream with valid/ready. Read bytes leave on a valid-only stream, one cycle per byte. Two one-cycle flags mark the end of the outgoing part and the end of the incoming part. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `qflash_seq`

## Requirements
- R1: The format code `fmt_i` sets the lanes per phase as (opcode, address, data). Code 0 is (1,1,1), with the outgoing bit on DQ0 and the incoming bit on DQ1. Code 1 behaves like code 0. Code 2 is (1,1,2), code 3 is (1,1,4), code 4 is (1,2,2), code 5 is (1,4,4), code 6 is (2,2,2) and code 7 is (4,4,4).
- R2: Each byte is shifted most significant bit first. In a slot that uses several lanes, DQ[n-1] carries the highest bit of the group, so on four lanes the first slot of a byte shows bits 7..4 on DQ3..DQ0.
- R3: The opcode byte is always sent. The address phase sends the low `addr_bytes_i` bytes of `addr_i`, highest byte first. A count of 0 leaves the phase out, and 3 and 4 are the usual counts.
- R4: Exactly `dummy_i` serial clocks are issued after the address and before the data phases. A count of 0 leaves the phase out.
- R5: The write phase takes `tx_len_i` bytes in order from the `tx_data_i`/`tx_valid_i`/`tx_ready_o` stream. While the next byte is missing, the serial clock is held low and the transaction resumes without loss.
- R6: The read phase samples the data lanes on each rising serial-clock edge. It emits `rx_len_i` bytes on `rx_data_o`, each with a one-cycle `rx_valid_o`.
- R7: `tx_done_o` pulses once per transaction, after the last opcode, address, dummy and write slot. `rx_done_o` pulses once, later, only if `rx_len_i` is nonzero. With no read bytes the transaction ends right after the outgoing part.
- R8: `cs_n_o` falls one serial-clock period (`2*HALF_DIV` cycles) before the first rising edge. It rises one period after the last falling edge. `sck_o` is low whenever `cs_n_o` is high.
- R9: During the opcode, address and write phases, exactly the lanes in use are enabled. During dummy and read phases of a multi-lane data format, all enables are off. In formats 0/1, only DQ0 is ever enabled and DQ1 is never enabled.
- R10: A `start_i` raised while `busy_o` is high does not alter the running transaction, and `start_err_o` pulses in the following cycle.
- R11: After reset, `cs_n_o` is 1, `sck_o` is 0, the enables are 0, and `busy_o` and `tx_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| fmt_i | input | 3 | Lane format code |
| cmd_i | input | 8 | Opcode byte |
| addr_i | input | 8*MAX_ADDR_BYTES | Flash address |
| addr_bytes_i | input | clog2(MAX_ADDR_BYTES+1) | Number of address bytes |
| dummy_i | input | DUMMY_W | Dummy clock count |
| tx_len_i | input | LEN_W | Bytes to write |
| rx_len_i | input | LEN_W | Bytes to read |
| busy_o | output | 1 | Transaction in progress |
| start_err_o | output | 1 | Start was rejected because the block was busy |
| tx_data_i | input | 8 | Write byte |
| tx_valid_i | input | 1 | Write byte available |
| tx_ready_o | output | 1 | Write byte taken this cycle if valid |
| rx_data_o | output | 8 | Read byte |
| rx_valid_o | output | 1 | Read byte strobe |
| tx_done_o | output | 1 | Outgoing part finished |
| rx_done_o | output | 1 | Incoming part finished |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| dq_o | output | 4 | Data line output values |
| dq_oe_o | output | 4 | Data line output enables |
| dq_i | input | 4 | Data line input values |

## Verification
The bench acts as a pin-level flash model and compares every rising-edge slot against a lane plan it computes itself. This catches a swapped lane order, a phase run on the wrong width, or an off-by-one in the address or dummy counts, because each of these shifts or garbles the slot list. Read data is driven from a separate pattern. A design that samples the wrong lane in single-line mode, or that leaves a lane driven during turnaround, returns wrong bytes or shows a bad enable mask. Write gaps on the stream, a start raised mid-transaction, and transactions without a read phase all target designs that drop bytes, restart, or raise a spurious read-done.

// File: rtl/qflash_pkg.sv
`timescale 1ns/1ps
package qflash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CMD, ST_ADDR, ST_DUMMY, ST_TX, ST_RX, ST_HOLD
  } seq_state_e;

  // log2 of lanes: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
  typedef logic [1:0] lane_log_t;

  typedef struct packed {
    lane_log_t cmd;
    lane_log_t adr;
    lane_log_t dat;
  } lane_plan_t;

  function automatic lane_plan_t decode_fmt(input logic [2:0] f);
    lane_plan_t p;
    case (f)
      3'd2:    p = '{cmd: 2'd0, adr: 2'd0, dat: 2'd1};
      3'd3:    p = '{cmd: 2'd0, adr: 2'd0, dat: 2'd2};
      3'd4:    p = '{cmd: 2'd0, adr: 2'd1, dat: 2'd1};
      3'd5:    p = '{cmd: 2'd0, adr: 2'd2, dat: 2'd2};
      3'd6:    p = '{cmd: 2'd1, adr: 2'd1, dat: 2'd1};
      3'd7:    p = '{cmd: 2'd2, adr: 2'd2, dat: 2'd2};
      default: p = '{cmd: 2'd0, adr: 2'd0, dat: 2'd0};
    endcase
    return p;
  endfunction

  // index of the last slot of a byte for a given lane width
  function automatic logic [2:0] slots_last(input lane_log_t lw);
    case (lw)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/qflash_tick.sv
`timescale 1ns/1ps
module qflash_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  generate
    if (HALF_DIV <= 1) begin : g_every
      assign tick_o = en_i;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          hit;
      assign hit    = (cnt_q == CW'(HALF_DIV - 1));
      assign tick_o = en_i && hit;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!en_i || hit) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/qflash_lanes.sv
`timescale 1ns/1ps
module qflash_lanes
  import qflash_pkg::*;
(
  input  logic [7:0] sreg_i,
  input  lane_log_t  lw_i,
  input  logic       drive_i,
  input  logic       keep_dq0_i,
  input  logic [3:0] dq_i,
  output logic [3:0] dq_o,
  output logic [3:0] oe_o,
  output logic [7:0] shout_o,
  output logic [7:0] shin_o
);
  logic [3:0] map;
  logic [3:0] mask;

  always_comb begin
    case (lw_i)
      2'd0: begin
        map     = {3'b000, sreg_i[7]};
        mask    = 4'b0001;
        shout_o = {sreg_i[6:0], 1'b0};
        shin_o  = {sreg_i[6:0], dq_i[1]};
      end
      2'd1: begin
        map     = {2'b00, sreg_i[7:6]};
        mask    = 4'b0011;
        shout_o = {sreg_i[5:0], 2'b00};
        shin_o  = {sreg_i[5:0], dq_i[1:0]};
      end
      default: begin
        map     = sreg_i[7:4];
        mask    = 4'b1111;
        shout_o = {sreg_i[3:0], 4'b0000};
        shin_o  = {sreg_i[3:0], dq_i[3:0]};
      end
    endcase
    dq_o = drive_i ? map : 4'b0000;
    oe_o = drive_i ? mask : (keep_dq0_i ? 4'b0001 : 4'b0000);
  end

  always_comb begin
    if (!$isunknown(oe_o))
      p_oe_shape_r9: assert (oe_o == 4'b0000 || oe_o == 4'b0001 ||
                             oe_o == 4'b0011 || oe_o == 4'b1111);
  end
endmodule

// File: rtl/qflash_seq.sv
`timescale 1ns/1ps
module qflash_seq
  import qflash_pkg::*;
#(
  parameter int HALF_DIV       = 2,
  parameter int LEN_W          = 16,
  parameter int DUMMY_W        = 5,
  parameter int MAX_ADDR_BYTES = 4,
  localparam int ADDR_W        = 8 * MAX_ADDR_BYTES,
  localparam int ABC_W         = $clog2(MAX_ADDR_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         fmt_i,
  input  logic [7:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ABC_W-1:0]   addr_bytes_i,
  input  logic [DUMMY_W-1:0] dummy_i,
  input  logic [LEN_W-1:0]   tx_len_i,
  input  logic [LEN_W-1:0]   rx_len_i,
  output logic               busy_o,
  output logic               start_err_o,
  input  logic [7:0]         tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic [7:0]         rx_data_o,
  output logic               rx_valid_o,
  output logic               tx_done_o,
  output logic               rx_done_o,
  output logic               cs_n_o,
  output logic               sck_o,
  output logic [3:0]         dq_o,
  output logic [3:0]         dq_oe_o,
  input  logic [3:0]         dq_i
);
  localparam int CNT_W = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W;

  seq_state_e         state_q, nxt_state;
  lane_plan_t         plan_q, start_plan;
  logic [ABC_W-1:0]   addr_n_q;
  logic [DUMMY_W-1:0] dummy_q;
  logic [LEN_W-1:0]   tx_len_q, rx_len_q;
  logic [ADDR_W-1:0]  addr_sh_q;
  logic [7:0]         sreg_q, rx_data_q;
  logic [2:0]         slot_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sck_q, need_ld_q;
  logic               tx_done_q, rx_done_q, rx_valid_q, err_q;

  logic       tick, tick_en, stall, shifting, rise, fall;
  logic       last_slot, last_unit, phase_end, drive, keep_dq0;
  lane_log_t  cur_lw;
  logic [7:0] lane_shout, lane_shin;
  seq_state_e after_tx, after_dummy, after_addr, after_cmd;

  assign start_plan = decode_fmt(fmt_i);

  always_comb begin
    case (state_q)
      ST_CMD:  cur_lw = plan_q.cmd;
      ST_ADDR: cur_lw = plan_q.adr;
      default: cur_lw = plan_q.dat;
    endcase
  end

  assign after_tx    = (rx_len_q != '0) ? ST_RX : ST_HOLD;
  assign after_dummy = (tx_len_q != '0) ? ST_TX : after_tx;
  assign after_addr  = (dummy_q  != '0) ? ST_DUMMY : after_dummy;
  assign after_cmd   = (addr_n_q != '0) ? ST_ADDR : after_addr;

  always_comb begin
    case (state_q)
      ST_CMD:   nxt_state = after_cmd;
      ST_ADDR:  nxt_state = after_addr;
      ST_DUMMY: nxt_state = after_dummy;
      ST_TX:    nxt_state = after_tx;
      ST_RX:    nxt_state = ST_HOLD;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  assign shifting  = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                     (state_q == ST_TX)  || (state_q == ST_RX);
  assign stall     = (state_q == ST_TX) && need_ld_q;
  assign tick_en   = (state_q != ST_IDLE) && !stall;
  assign rise      = tick && !sck_q && (shifting || state_q == ST_DUMMY);
  assign fall      = tick && sck_q;
  assign last_slot = (slot_q == 3'd0);
  assign last_unit = (cnt_q == '0);
  assign phase_end = fall && last_unit && (state_q == ST_DUMMY || last_slot);
  assign drive     = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_TX);
  assign keep_dq0  = (state_q == ST_DUMMY || state_q == ST_RX) && (plan_q.dat == 2'd0);

  qflash_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en),
    .tick_o (tick)
  );

  qflash_lanes u_lanes (
    .sreg_i     (sreg_q),
    .lw_i       (cur_lw),
    .drive_i    (drive),
    .keep_dq0_i (keep_dq0),
    .dq_i       (dq_i),
    .dq_o       (dq_o),
    .oe_o       (dq_oe_o),
    .shout_o    (lane_shout),
    .shin_o     (lane_shin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      plan_q     <= '0;
      addr_n_q   <= '0;
      dummy_q    <= '0;
      tx_len_q   <= '0;
      rx_len_q   <= '0;
      addr_sh_q  <= '0;
      sreg_q     <= '0;
      rx_data_q  <= '0;
      slot_q     <= '0;
      cnt_q      <= '0;
      sck_q      <= 1'b0;
      need_ld_q  <= 1'b0;
      tx_done_q  <= 1'b0;
      rx_done_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      tx_done_q  <= 1'b0;
      rx_done_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      err_q      <= start_i && (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: if (start_i) begin
          plan_q    <= start_plan;
          addr_n_q  <= addr_bytes_i;
          dummy_q   <= dummy_i;
          tx_len_q  <= tx_len_i;
          rx_len_q  <= rx_len_i;
          addr_sh_q <= addr_i << (8 * (MAX_ADDR_BYTES - int'(addr_bytes_i)));
          sreg_q    <= cmd_i;
          slot_q    <= slots_last(start_plan.cmd);
          cnt_q     <= '0;
          need_ld_q <= 1'b0;
          sck_q     <= 1'b0;
          state_q   <= ST_SETUP;
        end
        ST_SETUP: if (tick) state_q <= ST_CMD;
        ST_HOLD: if (tick) begin
          if (last_unit) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: begin
          if (stall && tx_valid_i) begin
            sreg_q    <= tx_data_i;
            need_ld_q <= 1'b0;
          end
          if (rise) begin
            sck_q <= 1'b1;
            if (state_q == ST_RX) sreg_q <= lane_shin;
          end
          if (fall) begin
            sck_q <= 1'b0;
            if (drive) sreg_q <= lane_shout;
            if (state_q == ST_RX && last_slot) begin
              rx_data_q  <= sreg_q;
              rx_valid_q <= 1'b1;
            end
            if (!phase_end) begin
              if (state_q == ST_DUMMY) begin
                cnt_q <= cnt_q - CNT_W'(1);
              end else if (last_slot) begin
                cnt_q  <= cnt_q - CNT_W'(1);
                slot_q <= slots_last(cur_lw);
                if (state_q == ST_ADDR) begin
                  sreg_q    <= addr_sh_q[ADDR_W-1 -: 8];
                  addr_sh_q <= {addr_sh_q[ADDR_W-9:0], 8'h00};
                end
                if (state_q == ST_TX) need_ld_q <= 1'b1;
              end else begin
                slot_q <= slot_q - 3'd1;
              end
            end
          end
          if (phase_end) begin
            state_q <= nxt_state;
            if (state_q == ST_RX) rx_done_q <= 1'b1;
            else if (nxt_state == ST_RX || nxt_state == ST_HOLD) tx_done_q <= 1'b1;
            case (nxt_state)
              ST_ADDR: begin
                sreg_q    <= addr_sh_q[ADDR_W-1 -: 8];
                addr_sh_q <= {addr_sh_q[ADDR_W-9:0], 8'h00};
                cnt_q     <= CNT_W'(addr_n_q) - CNT_W'(1);
                slot_q    <= slots_last(plan_q.adr);
              end
              ST_DUMMY: cnt_q <= CNT_W'(dummy_q) - CNT_W'(1);
              ST_TX: begin
                cnt_q     <= CNT_W'(tx_len_q) - CNT_W'(1);
                slot_q    <= slots_last(plan_q.dat);
                need_ld_q <= 1'b1;
              end
              ST_RX: begin
                cnt_q  <= CNT_W'(rx_len_q) - CNT_W'(1);
                slot_q <= slots_last(plan_q.dat);
              end
              default: cnt_q <= CNT_W'(1);
            endcase
          end
        end
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign start_err_o = err_q;
  assign tx_ready_o  = stall;
  assign rx_data_o   = rx_data_q;
  assign rx_valid_o  = rx_valid_q;
  assign tx_done_o   = tx_done_q;
  assign rx_done_o   = rx_done_q;
  assign cs_n_o      = (state_q == ST_IDLE);
  assign sck_o       = sck_q;

  p_sck_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);
  p_reject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> start_err_o);
  p_plan_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && state_q != ST_HOLD) |=> $stable(plan_q));
  p_single_dq1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plan_q == '0) |-> !dq_oe_o[1]);
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_DUMMY || state_q == ST_RX) && plan_q.dat != 2'd0) |-> (dq_oe_o == 4'b0000));
  p_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_done_o && rx_done_o));
  p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> $stable(sck_o));
  p_rx_in_xfer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !cs_n_o);
endmodule

// File: tb/qflash_seq_bench.sv
`timescale 1ns/1ps
module qflash_seq_bench;
  localparam int HALF = 2;
  localparam int PER  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  fmt_i = '0;
  logic [7:0]  cmd_i = '0;
  logic [31:0] addr_i = '0;
  logic [2:0]  addr_bytes_i = '0;
  logic [4:0]  dummy_i = '0;
  logic [15:0] tx_len_i = '0, rx_len_i = '0;
  logic        busy_o, start_err_o, tx_ready_o, rx_valid_o, tx_done_o, rx_done_o;
  logic        cs_n_o, sck_o;
  logic [7:0]  tx_data_i, rx_data_o;
  logic        tx_valid_i;
  logic [3:0]  dq_o, dq_oe_o;
  logic [3:0]  dq_i = '0;

  always #(PER/2) clk = ~clk;

  qflash_seq #(.HALF_DIV(HALF)) u_qflash_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .fmt_i(fmt_i), .cmd_i(cmd_i),
    .addr_i(addr_i), .addr_bytes_i(addr_bytes_i), .dummy_i(dummy_i),
    .tx_len_i(tx_len_i), .rx_len_i(rx_len_i), .busy_o(busy_o), .start_err_o(start_err_o),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .tx_done_o(tx_done_o),
    .rx_done_o(rx_done_o), .cs_n_o(cs_n_o), .sck_o(sck_o), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .dq_i(dq_i));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // expected slot plan and slave drive values
  logic [3:0] exp_dq [256];
  logic [3:0] exp_oe [256];
  bit         exp_cmp[256];
  logic [3:0] in_val [256];
  logic [3:0] rec_dq [256];
  logic [3:0] rec_oe [256];
  int n_exp, rec_cnt;
  logic [7:0] tx_mem [16];
  logic [7:0] rx_mem [16];
  logic [7:0] rx_got [16];
  int tx_n = 0, tx_idx = 0, rx_n = 0, cyc = 0;
  bit gap = 0;
  int txd_cnt, rxd_cnt, err_cnt;
  time txd_t, rxd_t, t_cs_fall, t_first_rise, t_last_fall, t_cs_rise;

  assign tx_valid_i = (tx_idx < tx_n) && !(gap && cyc[2]);
  assign tx_data_i  = tx_mem[tx_idx[3:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid_i && tx_ready_o) tx_idx <= tx_idx + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_valid_o && rx_n < 16) begin rx_got[rx_n] = rx_data_o; rx_n++; end
    if (tx_done_o) begin txd_cnt++; txd_t = $time; end
    if (rx_done_o) begin rxd_cnt++; rxd_t = $time; end
    if (start_err_o) err_cnt++;
  end

  // pin-level flash model
  always @(posedge sck_o) begin
    #1;
    if (!cs_n_o && rec_cnt < 256) begin
      if (rec_cnt == 0) t_first_rise = $time - 1;
      rec_dq[rec_cnt] = dq_o;
      rec_oe[rec_cnt] = dq_oe_o;
      rec_cnt++;
    end
  end
  always @(negedge sck_o) begin
    t_last_fall = $time;
    #1 dq_i = in_val[rec_cnt[7:0]];
  end
  always @(negedge cs_n_o) begin
    t_cs_fall = $time;
    #1 dq_i = in_val[0];
  end
  always @(posedge cs_n_o) t_cs_rise = $time;

  function automatic int lanes(input int f, input int ph);
    case (ph)
      0: return (f == 6) ? 2 : (f == 7) ? 4 : 1;
      1: return (f == 4 || f == 6) ? 2 : (f == 5 || f == 7) ? 4 : 1;
      default: return (f == 2 || f == 4 || f == 6) ? 2 : (f == 3 || f == 5 || f == 7) ? 4 : 1;
    endcase
  endfunction

  // kind: 0 driven byte, 1 read byte, 2 dummy slot
  task automatic add_byte(input logic [7:0] b, input int w, input int kind);
    int m = (1 << w) - 1;
    for (int j = 0; j < 8 / w; j++) begin
      logic [3:0] v = 4'((b >> (8 - w * (j + 1))) & m);
      if (kind == 0) begin
        exp_dq[n_exp] = v; exp_oe[n_exp] = 4'(m); exp_cmp[n_exp] = 1; in_val[n_exp] = 4'hA;
      end else begin
        exp_dq[n_exp] = 0; exp_oe[n_exp] = (w == 1) ? 4'b0001 : 4'b0000; exp_cmp[n_exp] = 0;
        in_val[n_exp] = (w == 1) ? {2'b00, v[0], 1'b0} : v;
      end
      n_exp++;
    end
  endtask

  task automatic xfer(input string tag, input int f, input logic [7:0] c, input logic [31:0] a,
                      input int ab, input int dm, input int txn, input int rxn,
                      input bit g, input bit poke);
    int bad_k = -1;
    int wd = lanes(f, 2);
    n_exp = 0; rec_cnt = 0; rx_n = 0; txd_cnt = 0; rxd_cnt = 0; err_cnt = 0;
    txd_t = 0; rxd_t = 0;
    for (int i = 0; i < 16; i++) begin
      tx_mem[i] = 8'(8'h5A + i * 29) ^ c;
      rx_mem[i] = 8'(8'hC3 ^ (i * 37)) ^ c;
    end
    add_byte(c, lanes(f, 0), 0);
    for (int i = 0; i < ab; i++) add_byte(8'(a >> (8 * (ab - 1 - i))), lanes(f, 1), 0);
    for (int i = 0; i < dm; i++) begin
      exp_dq[n_exp] = 0; exp_oe[n_exp] = (wd == 1) ? 4'b0001 : 4'b0000;
      exp_cmp[n_exp] = 0; in_val[n_exp] = 4'h5; n_exp++;
    end
    for (int i = 0; i < txn; i++) add_byte(tx_mem[i], wd, 0);
    for (int i = 0; i < rxn; i++) add_byte(rx_mem[i], wd, 1);
    in_val[n_exp] = 4'h0;
    @(negedge clk);
    tx_idx = 0; tx_n = txn; gap = g;
    fmt_i = 3'(f); cmd_i = c; addr_i = a; addr_bytes_i = 3'(ab); dummy_i = 5'(dm);
    tx_len_i = 16'(txn); rx_len_i = 16'(rxn); start_i = 1;
    @(negedge clk) start_i = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      fmt_i = 3'd7; cmd_i = 8'hFF; addr_bytes_i = 0; start_i = 1;
      @(negedge clk) start_i = 0;
    end
    do @(negedge clk); while (busy_o);
    repeat (4) @(negedge clk);
    chk(rec_cnt == n_exp, {tag, " R3/R4 slot count"}, rec_cnt, n_exp);
    for (int k = 0; k < n_exp && k < rec_cnt; k++)
      if (rec_oe[k] !== exp_oe[k] || (exp_cmp[k] && (rec_dq[k] & exp_oe[k]) !== exp_dq[k]))
        if (bad_k < 0) bad_k = k;
    chk(bad_k < 0, {tag, " R1/R2/R9 slot lanes (oe,dq) at slot"},
        (bad_k < 0) ? 0 : {rec_oe[bad_k], rec_dq[bad_k]},
        (bad_k < 0) ? 0 : {exp_oe[bad_k], exp_dq[bad_k]});
    chk(rx_n == rxn, {tag, " R6 read byte count"}, rx_n, rxn);
    for (int i = 0; i < rxn && i < rx_n; i++)
      chk(rx_got[i] === rx_mem[i], {tag, " R6 read byte"}, rx_got[i], rx_mem[i]);
    if (txn > 0) chk(tx_idx == txn, {tag, " R5 write bytes taken"}, tx_idx, txn);
    chk(txd_cnt == 1, {tag, " R7 tx_done pulses"}, txd_cnt, 1);
    chk(rxd_cnt == ((rxn > 0) ? 1 : 0), {tag, " R7 rx_done pulses"}, rxd_cnt, (rxn > 0) ? 1 : 0);
    if (rxn > 0) chk(txd_t < rxd_t, {tag, " R7 done order"}, txd_t, rxd_t);
    chk(t_first_rise - t_cs_fall == 2 * HALF * PER, {tag, " R8 select setup"},
        t_first_rise - t_cs_fall, 2 * HALF * PER);
    chk(t_cs_rise - t_last_fall == 2 * HALF * PER, {tag, " R8 select hold"},
        t_cs_rise - t_last_fall, 2 * HALF * PER);
    chk(err_cnt == (poke ? 1 : 0), {tag, " R10 start_err pulses"}, err_cnt, poke ? 1 : 0);
  endtask

  task automatic t_reset();
    chk(cs_n_o === 1'b1, "R11 cs_n after reset", cs_n_o, 1);
    chk(sck_o === 1'b0, "R11 sck after reset", sck_o, 0);
    chk(dq_oe_o === 4'b0, "R11 oe after reset", dq_oe_o, 0);
    chk(busy_o === 1'b0, "R11 busy after reset", busy_o, 0);
    chk(tx_ready_o === 1'b0, "R11 tx_ready after reset", tx_ready_o, 0);
  endtask

  initial begin
    #(150000 * PER);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    xfer("id_read",    0, 8'h9F, 32'h0,        0, 0, 0, 3, 0, 0);
    xfer("opcode_only",1, 8'h06, 32'h0,        0, 0, 0, 0, 0, 0);
    xfer("quad_out",   3, 8'h6B, 32'h12A5C3,   3, 8, 0, 4, 0, 0);
    xfer("quad_io",    5, 8'hEB, 32'h00F00D,   3, 4, 0, 5, 0, 0);
    xfer("quad_write", 7, 8'h32, 32'hDEADBEEF, 4, 0, 4, 0, 1, 0);
    xfer("dual_wr_rd", 2, 8'h3B, 32'h0,        0, 2, 2, 2, 0, 0);
    xfer("dual_full",  6, 8'hBB, 32'h89ABCDEF, 4, 1, 0, 2, 0, 0);
    xfer("dual_addr",  4, 8'hA2, 32'h345678,   3, 0, 3, 0, 1, 0);
    xfer("busy_poke",  0, 8'h03, 32'h010203,   3, 0, 1, 2, 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule